// File: doc/BRIEF.md
# Auxiliary ADC Conversion Controller

This block runs the control side of two auxiliary converter channels, A and B. Software writes a control register and a clock-select register. The control register chooses, for each channel, which of two analog inputs is sampled and whether the internal or the external reference is used. It also holds the setting for a dedicated serial control mode and the channel that this mode serves. Writing a one to a channel's start bit begins a conversion. The start bits do not hold their value and always read back as zero.

A strobe at the base sample rate is divided by 2 or by 4 to form the conversion clock enable. A simple digital model stands in for the analog converter. It takes the selected input's 10-bit code on the start cycle, then counts a fixed number of conversion enables and delivers the result. Each result is split across two read-only registers: one holds the upper eight bits and the other holds the lower two. Both registers are loaded on the same edge, so a reader never sees half of an old result and half of a new one.

Top module: `aux_adc_ctl`

Register map (`wr_addr`/`rd_addr`): 0 control, 1 clock select, 2 channel A upper, 3 channel A lower, 4 channel B upper, 5 channel B lower. Every other address reads zero.

## Requirements
- R1: After reset every register reads 0, both busy flags are low, and all select, reference and serial-mode outputs are low.
- R2: Control register bits map as follows. Bit 1 selects the input for A and bit 4 the input for B: 1 selects input 1 and 0 selects input 2. Bit 2 sets the reference for A and bit 5 the reference for B: 1 selects internal and 0 selects external. Bit 7 enables serial mode and bit 6 picks its channel (0 = A, 1 = B). These bits read back as written, and bits 0 and 3 always read 0.
- R3: The `conv_en` output pulses only on cycles where `smp_en` is high. It fires on every 2nd `smp_en` when clock-select bit 0 is 0, and on every 4th when that bit is 1. The counting phase persists across mode changes, and `conv_en` is never high on two consecutive cycles.
- R4: Writing control bit 0 (A) or bit 3 (B) as 1 while that channel is idle raises its busy flag on the next cycle. On the write cycle the channel captures the code of the input selected by the select bit in that same write.
- R5: A busy channel finishes on its CONV_CYC-th `conv_en` after the start cycle (default 12). On that edge busy clears, and the upper and lower result registers are both loaded. They change at no other time.
- R6: A start written while the channel is busy, including on its completing cycle, is ignored. Busy, the count and the captured code are unaffected, but the other control bits in that write still take effect.
- R7: The upper result register holds result bits 9..2. The lower register holds result bits 1..0 in its bits 1..0, and its bits 7..2 are zero.
- R8: Channels A and B run independently. Both may be busy at once, and each captures its own selected input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Base sample-rate strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Combinational read data |
| ain_a1 | input | 10 | Channel A input 1 code |
| ain_a2 | input | 10 | Channel A input 2 code |
| ain_b1 | input | 10 | Channel B input 1 code |
| ain_b2 | input | 10 | Channel B input 2 code |
| conv_en | output | 1 | Conversion clock enable |
| sel_in1_a | output | 1 | Channel A uses input 1 |
| sel_in1_b | output | 1 | Channel B uses input 1 |
| ref_int_a | output | 1 | Channel A uses internal reference |
| ref_int_b | output | 1 | Channel B uses internal reference |
| ser_en | output | 1 | Serial control mode enabled |
| ser_chan_b | output | 1 | Serial mode serves channel B |
| busy_a | output | 1 | Channel A converting |
| busy_b | output | 1 | Channel B converting |

## Verification
The hardest case to reach is a start request that lands while its channel is busy, and in particular one that lands on the very cycle the conversion completes. Directed stimulus sets up the first case: it changes the input code after a start, issues a second start mid-conversion, and then checks that the first code is the one delivered. For the second case, a long stretch of random control writes with random strobe gaps and a changing divide mode keeps both channels busy. Under that load, writes eventually coincide with the completing edge, and a cycle-accurate behavioural model checks every output on every clock.

// File: rtl/aux_adc_ctl.sv
module aux_adc_ctl #(
  parameter int CONV_CYC = 12,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [9:0]    ain_a1,
  input  logic [9:0]    ain_a2,
  input  logic [9:0]    ain_b1,
  input  logic [9:0]    ain_b2,
  output logic          conv_en,
  output logic          sel_in1_a,
  output logic          sel_in1_b,
  output logic          ref_int_a,
  output logic          ref_int_b,
  output logic          ser_en,
  output logic          ser_chan_b,
  output logic          busy_a,
  output logic          busy_b
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CLK  = AW'(1);
  localparam logic [AW-1:0] A_AHI  = AW'(2);
  localparam logic [AW-1:0] A_ALO  = AW'(3);
  localparam logic [AW-1:0] A_BHI  = AW'(4);
  localparam logic [AW-1:0] A_BLO  = AW'(5);

  logic [7:0] ctrl_q;
  logic       div4_q;
  logic [1:0] dcnt;
  logic       busy_r [2];
  logic [CW-1:0] cnt_r [2];
  logic [9:0] samp_r [2];
  logic [9:0] res_r  [2];
  logic [9:0] in1 [2];
  logic [9:0] in2 [2];

  wire ctrl_wr = wr_en && wr_addr == A_CTRL;
  wire clk_wr  = wr_en && wr_addr == A_CLK;

  assign in1[0] = ain_a1;
  assign in1[1] = ain_b1;
  assign in2[0] = ain_a2;
  assign in2[1] = ain_b2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div4_q <= 1'b0;
      dcnt   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data & 8'hF6;
      if (clk_wr)  div4_q <= wr_data[0];
      if (smp_en)  dcnt <= dcnt + 2'd1;
    end
  end

  assign conv_en = smp_en && (div4_q ? (dcnt == 2'd3) : dcnt[0]);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire start = ctrl_wr && wr_data[3*c];
    wire done  = busy_r[c] && conv_en && cnt_r[c] == LAST;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_r[c] <= 1'b0;
        cnt_r[c]  <= '0;
        samp_r[c] <= '0;
        res_r[c]  <= '0;
      end else if (done) begin
        busy_r[c] <= 1'b0;
        cnt_r[c]  <= '0;
        res_r[c]  <= samp_r[c];
      end else if (busy_r[c]) begin
        if (conv_en) cnt_r[c] <= cnt_r[c] + 1'b1;
      end else if (start) begin
        busy_r[c] <= 1'b1;
        samp_r[c] <= wr_data[3*c+1] ? in1[c] : in2[c];
      end
    end
  end

  assign busy_a     = busy_r[0];
  assign busy_b     = busy_r[1];
  assign sel_in1_a  = ctrl_q[1];
  assign ref_int_a  = ctrl_q[2];
  assign sel_in1_b  = ctrl_q[4];
  assign ref_int_b  = ctrl_q[5];
  assign ser_chan_b = ctrl_q[6];
  assign ser_en     = ctrl_q[7];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_CLK:   rd_data = {7'd0, div4_q};
      A_AHI:   rd_data = res_r[0][9:2];
      A_ALO:   rd_data = {6'd0, res_r[0][1:0]};
      A_BHI:   rd_data = res_r[1][9:2];
      A_BLO:   rd_data = {6'd0, res_r[1][1:0]};
      default: rd_data = '0;
    endcase
  end
endmodule

module aux_adc_ctl_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_en,
  input logic          conv_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          busy_a,
  input logic          busy_b
);
  // R3
  ce_needs_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> smp_en);
  // R3
  ce_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |=> !conv_en);
  // R2
  start_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == AW'(0) |-> (rd_data[0] == 1'b0 && rd_data[3] == 1'b0));
  // R4
  start_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0) && wr_data[0] && !busy_a) |=> busy_a);
  // R4
  start_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0) && wr_data[3] && !busy_b) |=> busy_b);
  // R5
  end_on_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_a && !conv_en) |=> busy_a);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(2) && $stable(rd_addr) && !$fell(busy_a)) |-> $stable(rd_data));
  // R7
  low_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(3) || rd_addr == AW'(5)) |-> rd_data[7:2] == 6'd0);
endmodule

bind aux_adc_ctl aux_adc_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .conv_en(conv_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .busy_a(busy_a), .busy_b(busy_b)
);

// File: tb/sim_aux_adc_ctl.sv
module sim_aux_adc_ctl;
  localparam int N = 12;
  logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [9:0] ain_a1 = '0, ain_a2 = '0, ain_b1 = '0, ain_b2 = '0;
  logic conv_en, sel_in1_a, sel_in1_b, ref_int_a, ref_int_b, ser_en, ser_chan_b, busy_a, busy_b;
  int checks = 0, fails = 0, mode = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  aux_adc_ctl #(.CONV_CYC(N), .AW(3)) u0 (.*);

  int m_ctrl, m_div4, m_dcnt;
  int m_busy [2], m_cnt [2], m_samp [2], m_res [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_div4 = 0; m_dcnt = 0;
      for (int c = 0; c < 2; c++) begin m_busy[c] = 0; m_cnt[c] = 0; m_samp[c] = 0; m_res[c] = 0; end
    end else begin
      automatic bit ce = smp_en && (m_div4 ? m_dcnt == 3 : m_dcnt % 2 == 1);
      automatic int ob [2];
      if (smp_en) m_dcnt = (m_dcnt + 1) % 4;
      for (int c = 0; c < 2; c++) begin
        ob[c] = m_busy[c];
        if (m_busy[c] && ce) begin
          if (m_cnt[c] == N - 1) begin m_res[c] = m_samp[c]; m_busy[c] = 0; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end
      end
      if (wr_en && wr_addr == 0) begin
        m_ctrl = wr_data & 8'hF6;
        if (wr_data[0] && !ob[0]) begin m_busy[0] = 1; m_samp[0] = wr_data[1] ? ain_a1 : ain_a2; end
        if (wr_data[3] && !ob[1]) begin m_busy[1] = 1; m_samp[1] = wr_data[4] ? ain_b1 : ain_b2; end
      end
      if (wr_en && wr_addr == 1) m_div4 = wr_data[0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_div4;
      2: return m_res[0] >> 2;
      3: return m_res[0] & 3;
      4: return m_res[1] >> 2;
      5: return m_res[1] & 3;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) if ($time > 20) begin
    chk("R3 conv_en", conv_en, smp_en && (m_div4 ? m_dcnt == 3 : m_dcnt % 2 == 1));
    chk("R4 busy_a", busy_a, m_busy[0]);
    chk("R8 busy_b", busy_b, m_busy[1]);
    chk("R2 selects", {ser_en, ser_chan_b, ref_int_b, sel_in1_b, ref_int_a, sel_in1_a},
        {m_ctrl[7], m_ctrl[6], m_ctrl[5], m_ctrl[4], m_ctrl[2], m_ctrl[1]});
    chk(rd_addr > 1 ? "R7 readback" : "R2 readback", rd_data, exp_rd(rd_addr));
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      wr_en = 0;
      smp_en = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      if (mode != 0) begin
        rd_addr = 3'($urandom % 8);
        ain_a1 = 10'($urandom); ain_a2 = 10'($urandom);
        ain_b1 = 10'($urandom); ain_b2 = 10'($urandom);
      end
    end
  endtask

  task automatic wr(int a, int d);
    step();
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
  endtask

  task automatic rd(string tag, int a, int exp);
    rd_addr = 3'(a); #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    ain_a1 = 10'h2AD; ain_a2 = 10'h155; ain_b1 = 10'h3C3; ain_b2 = 10'h00F;
    step(3); rst_n = 1;
    for (int a = 0; a < 6; a++) rd("R1 reset readback", a, 0);
    chk("R1 reset busy", {busy_a, busy_b}, 0);
    chk("R1 reset outputs", {sel_in1_a, sel_in1_b, ref_int_a, ref_int_b, ser_en, ser_chan_b}, 0);
    wr(1, 0);
    wr(0, 8'h83);
    step(4);
    ain_a1 = 10'h111;
    wr(0, 8'h83);
    step(40);
    rd("R5 A upper", 2, 8'hAB);
    rd("R6 A lower keeps first code", 3, 1);
    rd("R2 ctrl readback", 0, 8'h82);
    wr(1, 1);
    wr(0, 8'h49);
    step(1);
    chk("R8 both busy", {busy_a, busy_b}, 2'b11);
    step(120);
    rd("R8 A upper", 2, 8'h55);
    rd("R8 A lower", 3, 1);
    rd("R8 B upper", 4, 8'h03);
    rd("R7 B lower", 5, 3);
    mode = 1;
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 4 == 0) wr(1, $urandom % 2);
      else wr(0, $urandom);
      step($urandom % 12);
    end
    step(200);
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule